// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block takes one input clock and produces two divided clocks, a fast one and a slow one, whose rising edges line up wherever they coincide. Both outputs come from a single shared phase counter, so no relative skew can build up between them. A mode input picks one of two operating modes. In the normal mode the fast output is the input divided by 2, and the slow output is the input divided by 4 or 6. In the quick mode the fast output is the input clock itself, and the slow output is divided by 2 or 3. A second select input chooses between the two slow ratios.

A freeze input stops the dividers and holds both outputs. It is captured on the falling input edge, so the internal run gate only opens or closes while the input clock is low. No shortened pulse can therefore reach the counter or the outputs. An asynchronous master reset clears every stage. After release, the first rising edge that the gate lets through starts both outputs together from phase zero. A change to either select input is held back until the slow output finishes its current period.

Top module: `cdiv_dual_ratio`

## Requirements
- R1: With `quick_mode` low, `fast_clk` is the input divided by 2. It goes high on the first counted rising edge and toggles on every counted rising edge after that (50% duty).
- R2: With `quick_mode` low, `slow_clk` divides by 4 when `slow_alt` is low and by 6 when it is high. It is high for the first half of each period (2 or 3 input periods) and low for the rest.
- R3: With `quick_mode` high, `fast_clk` equals the input clock while the run gate is open, and stays low while it is closed.
- R4: With `quick_mode` high, `slow_clk` divides by 2 when `slow_alt` is low and by 3 when it is high. In both cases it is high for one input period per slow period.
- R5: Every rising edge of `slow_clk` coincides with a rising edge of `fast_clk`.
- R6: While the gate is closed (`freeze` high), the phase counter, the applied selection and both registered outputs hold their values. While it is open (`freeze` low), they advance on every rising input edge.
- R7: `freeze` is sampled on the falling edge of `clk_in` and governs the rising edge that follows. No high pulse on either output is shorter than half an input period.
- R8: While `mreset` is high, both outputs are low. Reset takes effect at once, without waiting for a clock edge.
- R9: After `mreset` falls, the first rising edge let through by the gate starts the counter at phase zero, and both outputs go high on that edge.
- R10: A change on `quick_mode` or `slow_alt` is applied only when the slow period wraps to phase zero, so no slow period is ever cut short or stretched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mreset | input | 1 | Asynchronous master reset, active high |
| freeze | input | 1 | High stops and holds the dividers; sampled on the falling clock edge |
| quick_mode | input | 1 | High: fast = /1, slow = /2 or /3. Low: fast = /2, slow = /4 or /6 |
| slow_alt | input | 1 | Slow ratio choice: low picks the smaller ratio (4 or 2), high the larger (6 or 3) |
| fast_clk | output | 1 | Fast divided clock |
| slow_clk | output | 1 | Slow divided clock |

## Verification
Assertions check the properties that must hold on every cycle. The phase stays inside the applied ratio. Nothing moves while the gate is closed. A new selection appears only at phase zero. The fast output toggles on every counted edge in the normal mode. A slow rising edge always comes with a fast rising edge. Reset keeps both outputs low. The exact periods and duty cycles for each selection, the falling-edge timing of `freeze`, the immediate action of reset between clock edges, the joint start after release and the minimum pulse width are shown only by the bench's scenarios. These sweep every selection, every selection change and a pseudo-random freeze pattern against an arithmetic model.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    // Selection as applied by the divider
    typedef struct packed {
        logic quick;   // fast = input clock, slow ratio halved
        logic alt;     // larger of the two slow ratios
    } cdiv_cfg_t;

    // Slow-output period in input cycles for a given selection
    function automatic int span_of(cdiv_cfg_t c, int lo, int hi);
        int r;
        r = c.alt ? hi : lo;
        return c.quick ? r / 2 : r;
    endfunction

endpackage

// File: rtl/cdiv_gate.sv
`timescale 1ns/1ps
module cdiv_gate (
    input  logic clk_in,
    input  logic mreset,
    input  logic freeze,
    output logic run_o,
    output logic gclk_o
);
    typedef struct packed {
        logic run;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = ~freeze;
    end

    // Updates only while clk_in is low, so the AND gate below never truncates a high phase
    always_ff @(negedge clk_in or posedge mreset) begin
        if (mreset) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign gclk_o = clk_in & st_q.run;

endmodule

// File: rtl/cdiv_seq.sv
`timescale 1ns/1ps
module cdiv_seq
    import cdiv_pkg::*;
#(
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 6,
    parameter int CNT_W    = 3
) (
    input  logic             clk_in,
    input  logic             mreset,
    input  logic             run_i,
    input  cdiv_cfg_t        cfg_i,
    output logic [CNT_W-1:0] cnt_nx_o,
    output cdiv_cfg_t        cfg_nx_o,
    output logic             started_nx_o,
    output logic             quick_o,
    output logic             started_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cdiv_cfg_t        cfg;
        logic             started;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic [CNT_W-1:0] last_c;

    always_comb begin
        last_c = CNT_W'(span_of(st_q.cfg, RATIO_LO, RATIO_HI) - 1);
        st_d   = st_q;
        if (run_i) begin
            if (!st_q.started || st_q.cnt == last_c) begin
                // period boundary: restart phase and take the pending selection
                st_d.cnt     = '0;
                st_d.cfg     = cfg_i;
                st_d.started = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_in or posedge mreset) begin
        if (mreset) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_nx_o     = st_d.cnt;
    assign cfg_nx_o     = st_d.cfg;
    assign started_nx_o = st_d.started;
    assign quick_o      = st_q.cfg.quick;
    assign started_o    = st_q.started;

    a_r2_phase_in_range: assert property (@(posedge clk_in) disable iff (mreset)
        st_q.started |-> (st_q.cnt <= last_c));

    a_r6_hold_when_gated: assert property (@(posedge clk_in) disable iff (mreset)
        !run_i |=> ($stable(st_q.cnt) && $stable(st_q.cfg)));

    a_r10_select_at_wrap: assert property (@(posedge clk_in) disable iff (mreset)
        (st_q.started && $past(st_q.started) && (st_q.cfg != $past(st_q.cfg)))
            |-> (st_q.cnt == '0));

endmodule

// File: rtl/cdiv_shape.sv
`timescale 1ns/1ps
module cdiv_shape
    import cdiv_pkg::*;
#(
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 6,
    parameter int CNT_W    = 3
) (
    input  logic             clk_in,
    input  logic             mreset,
    input  logic             gclk_i,
    input  logic             run_i,
    input  logic             started_i,
    input  logic             quick_i,
    input  logic [CNT_W-1:0] cnt_nx_i,
    input  cdiv_cfg_t        cfg_nx_i,
    input  logic             started_nx_i,
    output logic             fast_o,
    output logic             slow_o
);
    typedef struct packed {
        logic fast;
        logic slow;
    } shape_st_t;

    shape_st_t        st_d, st_q;
    logic [CNT_W-1:0] half_c;

    always_comb begin
        half_c    = CNT_W'(span_of(cfg_nx_i, RATIO_LO, RATIO_HI) / 2);
        st_d      = st_q;
        st_d.slow = started_nx_i && (cnt_nx_i < half_c);
        st_d.fast = started_nx_i && !cnt_nx_i[0];
    end

    always_ff @(posedge clk_in or posedge mreset) begin
        if (mreset) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fast_o = quick_i ? gclk_i : st_q.fast;
    assign slow_o = st_q.slow;

    a_r1_fast_toggles: assert property (@(posedge clk_in) disable iff (mreset)
        (run_i && !quick_i) |=> (st_q.fast != $past(st_q.fast)));

    a_r5_rise_together: assert property (@(posedge clk_in) disable iff (mreset)
        ($rose(st_q.slow) && !quick_i && !$past(quick_i)) |-> $rose(st_q.fast));

    a_r8_reset_low: assert property (@(posedge clk_in)
        mreset |-> (!st_q.slow && !st_q.fast && !started_i));

endmodule

// File: rtl/cdiv_dual_ratio.sv
`timescale 1ns/1ps
module cdiv_dual_ratio
    import cdiv_pkg::*;
#(
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 6
) (
    input  logic clk_in,
    input  logic mreset,
    input  logic freeze,
    input  logic quick_mode,
    input  logic slow_alt,
    output logic fast_clk,
    output logic slow_clk
);
    localparam int CNT_W = $clog2(RATIO_HI);

    logic             run_w;
    logic             gclk_w;
    cdiv_cfg_t        cfg_req;
    logic [CNT_W-1:0] cnt_nx_w;
    cdiv_cfg_t        cfg_nx_w;
    logic             started_nx_w;
    logic             quick_w;
    logic             started_w;

    assign cfg_req.quick = quick_mode;
    assign cfg_req.alt   = slow_alt;

    cdiv_gate u_gate (
        .clk_in (clk_in),
        .mreset (mreset),
        .freeze (freeze),
        .run_o  (run_w),
        .gclk_o (gclk_w)
    );

    cdiv_seq #(
        .RATIO_LO (RATIO_LO),
        .RATIO_HI (RATIO_HI),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk_in       (clk_in),
        .mreset       (mreset),
        .run_i        (run_w),
        .cfg_i        (cfg_req),
        .cnt_nx_o     (cnt_nx_w),
        .cfg_nx_o     (cfg_nx_w),
        .started_nx_o (started_nx_w),
        .quick_o      (quick_w),
        .started_o    (started_w)
    );

    cdiv_shape #(
        .RATIO_LO (RATIO_LO),
        .RATIO_HI (RATIO_HI),
        .CNT_W    (CNT_W)
    ) u_shape (
        .clk_in       (clk_in),
        .mreset       (mreset),
        .gclk_i       (gclk_w),
        .run_i        (run_w),
        .started_i    (started_w),
        .quick_i      (quick_w),
        .cnt_nx_i     (cnt_nx_w),
        .cfg_nx_i     (cfg_nx_w),
        .started_nx_i (started_nx_w),
        .fast_o       (fast_clk),
        .slow_o       (slow_clk)
    );

endmodule

// File: tb/cdiv_dual_ratio_test.sv
`timescale 1ns/1ps
module cdiv_dual_ratio_test;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic frz = 1'b0;
    logic qm  = 1'b0;
    logic alt = 1'b0;
    logic fast;
    logic slow;

    always #2 clk = ~clk;   // 250 MHz

    cdiv_dual_ratio uut (
        .clk_in     (clk),
        .mreset     (rst),
        .freeze     (frz),
        .quick_mode (qm),
        .slow_alt   (alt),
        .fast_clk   (fast),
        .slow_clk   (slow)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    int p = 0;
    bit st = 0, cfq = 0, cfa = 0, live = 0, prev_s = 0;
    bit armed = 0;
    bit [7:0] lf = 8'hA5;
    realtime tf_f = 0.0, tf_s = 0.0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nb(input bit q, input bit a);
        return q ? (a ? 3 : 2) : (a ? 6 : 4);
    endfunction

    // R7: minimum high-pulse width, half an input period (2 ns)
    always @(posedge fast) tf_f = $realtime;
    always @(posedge slow) tf_s = $realtime;
    always @(negedge fast) if (armed && tf_f > 0.0)
        chk(($realtime - tf_f) > 1.99, "R7 fast pulse width ps",
            int'(($realtime - tf_f) * 1000.0), 2000);
    always @(negedge slow) if (armed && tf_s > 0.0)
        chk(($realtime - tf_s) > 1.99, "R7 slow pulse width ps",
            int'(($realtime - tf_s) * 1000.0), 2000);

    task automatic do_reset(input bit q, input bit a);
        armed = 0;
        @(posedge clk); #1;
        rst = 1'b1; qm = q; alt = a; frz = 1'b0;
        #0.5;
        chk(slow == 1'b0, "R8 slow low at once", int'(slow), 0);
        chk(fast == 1'b0, "R8 fast low at once", int'(fast), 0);
        @(posedge clk); #1;
        chk(slow == 1'b0, "R8 slow held low", int'(slow), 0);
        chk(fast == 1'b0, "R8 fast held low", int'(fast), 0);
        rst = 1'b0;
        p = 0; st = 0; cfq = 0; cfa = 0; live = 1; prev_s = 0;
        armed = 1;
    endtask

    // One input period: model edge at posedge, sample high phase, drive, sample low phase
    task automatic cycle(input bit f_nx, input bit q_nx, input bit a_nx);
        bit    exp_s, exp_f0, exp_fh, exp_fl, first, chg;
        string pre;
        @(posedge clk);
        first = 0; chg = 0;
        if (live) begin
            if (!st || p == nb(cfq, cfa) - 1) begin
                first = !st;
                chg   = st && ((cfq != qm) || (cfa != alt));
                cfq = qm; cfa = alt; p = 0; st = 1;
            end else begin
                p++;
            end
        end
        exp_s  = st && (p < nb(cfq, cfa) / 2);
        exp_f0 = st && (p % 2 == 0);
        exp_fh = cfq ? live : exp_f0;
        exp_fl = cfq ? 1'b0 : exp_f0;
        pre = "";
        if (!live) pre = {pre, "R6/R7 held "};
        if (first) pre = {pre, "R9 first edge "};
        if (chg)   pre = {pre, "R10 new select "};
        #1;
        chk(fast == exp_fh, {pre, cfq ? "R3 fast high phase" : "R1 fast"}, int'(fast), int'(exp_fh));
        chk(slow == exp_s,  {pre, cfq ? "R4 slow" : "R2 slow"}, int'(slow), int'(exp_s));
        if (exp_s && !prev_s)
            chk(fast == 1'b1, "R5 slow rise without fast rise", int'(fast), 1);
        prev_s = exp_s;
        frz = f_nx; qm = q_nx; alt = a_nx;
        #2;
        chk(fast == exp_fl, {pre, cfq ? "R3 fast low phase" : "R1 fast low phase"}, int'(fast), int'(exp_fl));
        chk(slow == exp_s,  {pre, "R2/R4 slow stable in low phase"}, int'(slow), int'(exp_s));
        live = !f_nx;   // R7: falling edge just sampled f_nx
    endtask

    initial begin
        #1 rst = 1'b1;
        @(posedge clk); #1;
        chk(slow == 1'b0, "R8 reset state slow", int'(slow), 0);
        chk(fast == 1'b0, "R8 reset state fast", int'(fast), 0);

        // free-running sweep over all four selections
        for (int s = 0; s < 4; s++) begin
            do_reset(s[1], s[0]);
            for (int c = 0; c < 25; c++) cycle(1'b0, s[1], s[0]);
        end

        // pseudo-random freeze pattern in every selection
        for (int s = 0; s < 4; s++) begin
            do_reset(s[1], s[0]);
            for (int c = 0; c < 60; c++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                cycle(lf[0] & lf[2], s[1], s[0]);
            end
            for (int c = 0; c < 3; c++) cycle(1'b0, s[1], s[0]);
        end

        // every selection change, injected at a varying phase
        for (int a0 = 0; a0 < 4; a0++) begin
            for (int b0 = 0; b0 < 4; b0++) begin
                do_reset(a0[1], a0[0]);
                for (int c = 0; c < 20; c++) begin
                    if (c >= 2 + ((a0 + b0) % 4)) cycle(1'b0, b0[1], b0[0]);
                    else                          cycle(1'b0, a0[1], a0[0]);
                end
            end
        end

        // R8: asynchronous reset between clock edges while slow is high
        do_reset(1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b1);
        chk(slow == 1'b1, "R2 slow high before async reset", int'(slow), 1);
        armed = 0;
        rst = 1'b1;
        #0.5;
        chk(slow == 1'b0, "R8 async reset slow", int'(slow), 0);
        chk(fast == 1'b0, "R8 async reset fast", int'(fast), 0);
        do_reset(1'b1, 1'b1);
        for (int c = 0; c < 7; c++) cycle(1'b0, 1'b1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule